// File: doc/BRIEF.md
# Chunk Log Packet Builder and Line Buffer

This block turns each chunk-termination event from a replay-recording core into fixed 128-bit log packets. It collects the packets in a small circular buffer whose entries are one cache line wide, and offers every completed line to memory as a single write. Timestamps are compressed. An absolute 64-bit time packet is logged when needed, and each chunk packet carries only a 32-bit difference from the most recent absolute value. When that difference no longer fits in 32 bits, the block asks the core to end the current chunk. The next termination then logs a fresh absolute packet followed by the chunk packet.

Completed lines are requested as soon as they fill. Memory accepts them on its ready signal, which stands for idle bus cycles, and line addresses come from a pointer that steps by one line. The block stalls the execution pipeline only when a pending termination cannot find room for its packets. The stall ends as soon as memory takes one line.

Top module: `chunklog_top`

## Requirements
- R1: Once reset is released and before any termination arrives, `mem_req`, `stall` and `ovf_term` are all 0.
- R2: The first accepted termination after reset logs two packets in order. The first is a time packet: bits [2:0]=1, bits [70:7]=`gtime`, all other bits 0. The second is the chunk packet with a difference of 0.
- R3: A chunk packet has bits [2:0]=0, [6:3]=reason, [38:7]=time difference, [58:39]=chunk size, [63:59]=store-window count, [79:64]=atomicity count, and [127:80]=0.
- R4: The time difference in a chunk packet equals `gtime` in the accepting cycle minus the most recently logged absolute time.
- R5: `ovf_term` is 1 exactly when an absolute time has been logged and `gtime` minus it is 2^32 or more. The next termination then logs a time packet carrying the current `gtime` and a chunk packet with difference 0, after which `ovf_term` returns to 0.
- R6: Packets fill a line in arrival order, packet n of a line sitting at bits [128n+127:128n]. Lines are offered in the order they filled.
- R7: `mem_req` rises in the cycle after the edge that writes the fourth packet of a line. While `mem_ready` is 0, `mem_req`, `mem_line` and `mem_addr` hold steady.
- R8: The first line is offered at address `LOG_BASE`. Each accepted line advances the address by 64.
- R9: `stall` is 1 when `term_valid` is 1 and the free packet slots are fewer than the packets the termination needs. A stalled termination logs nothing. It is accepted, once only, after one line has been taken by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_valid | input | 1 | Chunk termination pending, held until accepted |
| term_reason | input | 4 | Termination cause code |
| term_size | input | 20 | Retired instructions in the chunk |
| term_rsw | input | 5 | Pending stores awaiting commit |
| term_iav | input | 16 | Retired memory transactions of the unfinished instruction |
| gtime | input | 64 | Global timestamp |
| mem_ready | input | 1 | Memory takes the offered line this cycle |
| stall | output | 1 | Pipeline stall request |
| ovf_term | output | 1 | Request to end the chunk because the time difference overflowed |
| mem_req | output | 1 | A full line is offered |
| mem_line | output | 512 | Offered line, packet 0 in the low bits |
| mem_addr | output | 32 | Byte address of the offered line |

## Verification
Packets are written on the clock edge that accepts a termination. A filled line therefore shows on `mem_req` and `mem_line` half a cycle later, at the next falling edge, and the bench samples it there. `stall` and `ovf_term` follow their inputs combinationally within the same cycle. The bench changes `term_valid` or `gtime` at a falling edge and reads these outputs 1 ns later, before the next rising edge. A line is taken on the rising edge where `mem_ready` is 1, and the address step and the release of a stall are checked at the falling edge that follows. The expected packets come from a queue the bench builds out of the field layout in the requirements.

// File: rtl/chunklog_pkg.sv
package chunklog_pkg;

    localparam int PKT_W   = 128;
    localparam int KIND_W  = 3;
    localparam int CAUSE_W = 4;
    localparam int DELTA_W = 32;
    localparam int CSIZE_W = 20;
    localparam int SWIN_W  = 5;
    localparam int ACNT_W  = 16;
    localparam int TS_W    = 64;

    localparam logic [KIND_W-1:0] KIND_CHUNK = 3'd0;
    localparam logic [KIND_W-1:0] KIND_STAMP = 3'd1;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CSIZE_W-1:0] csize;
        logic [SWIN_W-1:0]  swin;
        logic [ACNT_W-1:0]  acount;
    } term_t;

    typedef struct packed {
        logic [PKT_W-KIND_W-CAUSE_W-DELTA_W-CSIZE_W-SWIN_W-ACNT_W-1:0] rsv;
        logic [ACNT_W-1:0]  acount;
        logic [SWIN_W-1:0]  swin;
        logic [CSIZE_W-1:0] csize;
        logic [DELTA_W-1:0] tdelta;
        logic [CAUSE_W-1:0] cause;
        logic [KIND_W-1:0]  kind;
    } chunk_pkt_t;

    typedef struct packed {
        logic [PKT_W-KIND_W-CAUSE_W-TS_W-1:0] rsv_hi;
        logic [TS_W-1:0]    tabs;
        logic [CAUSE_W-1:0] rsv_lo;
        logic [KIND_W-1:0]  kind;
    } stamp_pkt_t;

    function automatic chunk_pkt_t make_chunk(term_t t, logic [DELTA_W-1:0] d);
        chunk_pkt_t p;
        p        = '0;
        p.kind   = KIND_CHUNK;
        p.cause  = t.cause;
        p.tdelta = d;
        p.csize  = t.csize;
        p.swin   = t.swin;
        p.acount = t.acount;
        return p;
    endfunction

    function automatic stamp_pkt_t make_stamp(logic [TS_W-1:0] ts);
        stamp_pkt_t p;
        p      = '0;
        p.kind = KIND_STAMP;
        p.tabs = ts;
        return p;
    endfunction

endpackage

// File: rtl/chunklog_stamp.sv
module chunklog_stamp
    import chunklog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [TS_W-1:0]    gtime,
    input  logic               load,
    output logic               need_abs,
    output logic [DELTA_W-1:0] delta,
    output logic               ovf_term,
    output logic               base_valid
);

    logic [TS_W-1:0] base_q;
    logic            valid_q;
    logic [TS_W-1:0] diff;
    logic            over;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            base_q  <= gtime;
            valid_q <= 1'b1;
        end
    end

    always_comb begin
        diff       = gtime - base_q;
        over       = valid_q && (diff[TS_W-1:DELTA_W] != '0);
        need_abs   = !valid_q || over;
        delta      = need_abs ? '0 : diff[DELTA_W-1:0];
        ovf_term   = over;
        base_valid = valid_q;
    end

endmodule

// File: rtl/chunklog_packer.sv
module chunklog_packer
    import chunklog_pkg::*;
(
    input  term_t              term,
    input  logic               need_abs,
    input  logic [DELTA_W-1:0] delta,
    input  logic [TS_W-1:0]    gtime,
    output logic [PKT_W-1:0]   pkt0,
    output logic [PKT_W-1:0]   pkt1,
    output logic               two
);

    chunk_pkt_t c_pkt;
    stamp_pkt_t s_pkt;

    always_comb begin
        c_pkt = make_chunk(term, delta);
        s_pkt = make_stamp(gtime);
        two   = need_abs;
        pkt0  = need_abs ? PKT_W'(s_pkt) : PKT_W'(c_pkt);
        pkt1  = PKT_W'(c_pkt);
    end

endmodule

// File: rtl/chunklog_linebuf.sv
module chunklog_linebuf
    import chunklog_pkg::*;
#(
    parameter int LINE_PKTS = 4,
    parameter int ENTRIES   = 4,
    parameter int ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] LOG_BASE = '0,
    localparam int SLOTS      = LINE_PKTS * ENTRIES,
    localparam int IDX_W      = $clog2(SLOTS),
    localparam int PTR_W      = IDX_W + 1,
    localparam int LP_W       = $clog2(LINE_PKTS),
    localparam int LINE_W     = LINE_PKTS * PKT_W,
    localparam int LINE_BYTES = LINE_W / 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_two,
    input  logic [PKT_W-1:0]  wr_pkt0,
    input  logic [PKT_W-1:0]  wr_pkt1,
    input  logic              mem_ready,
    output logic [PTR_W-1:0]  occ,
    output logic [PTR_W-1:0]  free_slots,
    output logic              mem_req,
    output logic [LINE_W-1:0] mem_line,
    output logic [ADDR_W-1:0] mem_addr
);

    logic [PKT_W-1:0]  slot_q [SLOTS];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  wr_idx, nxt_idx;
    logic [IDX_W-LP_W-1:0] rd_line;
    logic              take;

    assign wr_idx  = wr_ptr_q[IDX_W-1:0];
    assign nxt_idx = wr_idx + IDX_W'(1);
    assign rd_line = rd_ptr_q[IDX_W-1:LP_W];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= wr_pkt0;
            if (wr_two) begin
                slot_q[nxt_idx] <= wr_pkt1;
            end
        end
    end

    always_comb begin
        occ        = wr_ptr_q - rd_ptr_q;
        free_slots = PTR_W'(SLOTS) - occ;
        mem_req    = occ >= PTR_W'(LINE_PKTS);
        take       = mem_req && mem_ready;
        mem_addr   = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            addr_q   <= LOG_BASE;
        end else begin
            if (wr_en) begin
                wr_ptr_q <= wr_ptr_q + (wr_two ? PTR_W'(2) : PTR_W'(1));
            end
            if (take) begin
                rd_ptr_q <= rd_ptr_q + PTR_W'(LINE_PKTS);
                addr_q   <= addr_q + ADDR_W'(LINE_BYTES);
            end
        end
    end

    for (genvar k = 0; k < LINE_PKTS; k++) begin : g_lane
        assign mem_line[k*PKT_W +: PKT_W] = slot_q[{rd_line, LP_W'(k)}];
    end

endmodule

// File: rtl/chunklog_top.sv
module chunklog_top
    import chunklog_pkg::*;
#(
    parameter int LINE_PKTS = 4,
    parameter int ENTRIES   = 4,
    parameter int ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] LOG_BASE = 'h0010_0000,
    localparam int SLOTS  = LINE_PKTS * ENTRIES,
    localparam int PTR_W  = $clog2(SLOTS) + 1,
    localparam int LINE_W = LINE_PKTS * PKT_W
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               term_valid,
    input  logic [CAUSE_W-1:0] term_reason,
    input  logic [CSIZE_W-1:0] term_size,
    input  logic [SWIN_W-1:0]  term_rsw,
    input  logic [ACNT_W-1:0]  term_iav,
    input  logic [TS_W-1:0]    gtime,
    input  logic               mem_ready,
    output logic               stall,
    output logic               ovf_term,
    output logic               mem_req,
    output logic [LINE_W-1:0]  mem_line,
    output logic [ADDR_W-1:0]  mem_addr
);

    term_t              term;
    logic               need_abs;
    logic [DELTA_W-1:0] delta;
    logic               base_valid;
    logic [PKT_W-1:0]   pkt0, pkt1;
    logic               two;
    logic               accept;
    logic [PTR_W-1:0]   occ, free_slots, need_cnt;

    assign term = '{cause: term_reason, csize: term_size, swin: term_rsw, acount: term_iav};

    chunklog_stamp u_stamp (
        .clk        (clk),
        .rst        (rst),
        .gtime      (gtime),
        .load       (accept && need_abs),
        .need_abs   (need_abs),
        .delta      (delta),
        .ovf_term   (ovf_term),
        .base_valid (base_valid)
    );

    chunklog_packer u_packer (
        .term     (term),
        .need_abs (need_abs),
        .delta    (delta),
        .gtime    (gtime),
        .pkt0     (pkt0),
        .pkt1     (pkt1),
        .two      (two)
    );

    always_comb begin
        need_cnt = two ? PTR_W'(2) : PTR_W'(1);
        stall    = term_valid && (free_slots < need_cnt);
        accept   = term_valid && !stall;
    end

    chunklog_linebuf #(
        .LINE_PKTS (LINE_PKTS),
        .ENTRIES   (ENTRIES),
        .ADDR_W    (ADDR_W),
        .LOG_BASE  (LOG_BASE)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept),
        .wr_two     (two),
        .wr_pkt0    (pkt0),
        .wr_pkt1    (pkt1),
        .mem_ready  (mem_ready),
        .occ        (occ),
        .free_slots (free_slots),
        .mem_req    (mem_req),
        .mem_line   (mem_line),
        .mem_addr   (mem_addr)
    );

endmodule

// File: rtl/chunklog_chk.sv
module chunklog_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 512,
    parameter int SLOTS  = 16,
    parameter int PTR_W  = 5
)(
    input logic              clk,
    input logic              rst,
    input logic              term_valid,
    input logic              stall,
    input logic              ovf_term,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [LINE_W-1:0] mem_line,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PTR_W-1:0]  occ,
    input logic              base_valid
);

    localparam int LINE_BYTES = LINE_W / 8;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_line) && $stable(mem_addr))); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (mem_addr == $past(mem_addr) + ADDR_W'(LINE_BYTES))); // R8

    AST_ADDR_STILL: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && mem_ready) |=> $stable(mem_addr)); // R8

    AST_STALL_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst)
        stall |-> term_valid); // R9

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        stall |-> (occ > PTR_W'(SLOTS - 2))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= PTR_W'(SLOTS)); // R9

    AST_OVF_AFTER_BASE: assert property (@(posedge clk) disable iff (rst)
        !base_valid |-> !ovf_term); // R5

endmodule

bind chunklog_top chunklog_chk #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .SLOTS  (SLOTS),
    .PTR_W  (PTR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .term_valid (term_valid),
    .stall      (stall),
    .ovf_term   (ovf_term),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_line   (mem_line),
    .mem_addr   (mem_addr),
    .occ        (occ),
    .base_valid (base_valid)
);

// File: tb/chunklog_tb.sv
module chunklog_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE_ADDR = 32'h0010_0000;
    localparam logic [63:0] TWO32 = 64'h1_0000_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         term_valid = 1'b0;
    logic [3:0]   term_reason = '0;
    logic [19:0]  term_size = '0;
    logic [4:0]   term_rsw = '0;
    logic [15:0]  term_iav = '0;
    logic [63:0]  gtime = '0;
    logic         mem_ready = 1'b0;
    logic         stall, ovf_term, mem_req;
    logic [511:0] mem_line;
    logic [31:0]  mem_addr;

    int n_checks = 0;
    int n_fails  = 0;
    logic [127:0] exp_q[$];
    logic [63:0]  m_base = '0;
    logic         m_valid = 1'b0;
    logic [31:0]  exp_addr = BASE_ADDR;

    always #(CLK_PERIOD/2) clk = ~clk;

    chunklog_top dut_i (
        .clk(clk), .rst(rst), .term_valid(term_valid), .term_reason(term_reason),
        .term_size(term_size), .term_rsw(term_rsw), .term_iav(term_iav),
        .gtime(gtime), .mem_ready(mem_ready), .stall(stall), .ovf_term(ovf_term),
        .mem_req(mem_req), .mem_line(mem_line), .mem_addr(mem_addr)
    );

    function automatic logic [127:0] want_chunk(logic [3:0] r, logic [19:0] s,
                                                logic [4:0] w, logic [15:0] a, logic [31:0] d);
        return {48'b0, a, w, s, d, r, 3'd0};
    endfunction

    function automatic logic [127:0] want_stamp(logic [63:0] t);
        return {57'b0, t, 4'b0, 3'd1};
    endfunction

    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Push the packets a termination is expected to log (R2, R3, R4, R5).
    task automatic model_accept(input logic [3:0] r, input logic [19:0] s,
                                input logic [4:0] w, input logic [15:0] a, input logic [63:0] t);
        if (!m_valid || (t - m_base) >= TWO32) begin
            exp_q.push_back(want_stamp(t));
            m_base  = t;
            m_valid = 1'b1;
        end
        exp_q.push_back(want_chunk(r, s, w, a, 32'(t - m_base)));
    endtask

    task automatic do_term(input logic [3:0] r, input logic [19:0] s,
                           input logic [4:0] w, input logic [15:0] a, input logic [63:0] t);
        @(negedge clk);
        term_valid = 1'b1; term_reason = r; term_size = s;
        term_rsw = w; term_iav = a; gtime = t;
        #1;
        while (stall) @(negedge clk);
        @(posedge clk);
        model_accept(r, s, w, a, t);
        @(negedge clk);
        term_valid = 1'b0;
    endtask

    // Take one line and compare it with the next four expected packets (R6, R8).
    task automatic drain_line(input string req);
        logic [511:0] want;
        @(negedge clk);
        check(mem_req === 1'b1, {req, " R7 mem_req"}, 512'(mem_req), 512'(1));
        for (int k = 0; k < 4; k++) begin
            want[k*128 +: 128] = (exp_q.size() > 0) ? exp_q.pop_front() : 128'hx;
        end
        check(mem_line === want, {req, " R6 line"}, mem_line, want);
        check(mem_addr === exp_addr, "R8 addr", 512'(mem_addr), 512'(exp_addr));
        mem_ready = 1'b1;
        @(posedge clk);
        exp_addr = exp_addr + 32'd64;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic t_reset;
        check(mem_req === 1'b0 && stall === 1'b0 && ovf_term === 1'b0, "R1 reset outputs",
              512'({mem_req, stall, ovf_term}), 512'(0));
    endtask

    task automatic t_first_line;
        do_term(4'd3, 20'd5, 5'd2, 16'd4, 64'd1000);
        do_term(4'd1, 20'hABCDE, 5'd31, 16'hFFFF, 64'd1500);
        check(mem_req === 1'b0, "R7 not full at three packets", 512'(mem_req), 512'(0));
        do_term(4'd9, 20'd77, 5'd0, 16'd3, 64'd1600);
        check(mem_req === 1'b1, "R7 req after fourth packet", 512'(mem_req), 512'(1));
        repeat (3) @(negedge clk);
        check(mem_req === 1'b1, "R7 req held without ready", 512'(mem_req), 512'(1));
        drain_line("R2 R3 R4");
        check(mem_req === 1'b0, "R7 req drops after take", 512'(mem_req), 512'(0));
    endtask

    task automatic t_overflow;
        @(negedge clk);
        gtime = 64'd1000 + TWO32 - 64'd1;
        #1;
        check(ovf_term === 1'b0, "R5 below limit", 512'(ovf_term), 512'(0));
        gtime = 64'd1000 + TWO32;
        #1;
        check(ovf_term === 1'b1, "R5 at limit", 512'(ovf_term), 512'(1));
        do_term(4'd6, 20'd12, 5'd1, 16'd1, 64'd1007 + TWO32);
        check(ovf_term === 1'b0, "R5 cleared after new stamp", 512'(ovf_term), 512'(0));
        do_term(4'd2, 20'd8, 5'd3, 16'd0, 64'd1010 + TWO32);
        do_term(4'd4, 20'd9, 5'd4, 16'd2, 64'd1016 + TWO32);
        drain_line("R5 R4");
    endtask

    task automatic t_stall;
        logic [63:0] t0;
        t0 = 64'd2000 + TWO32;
        for (int i = 0; i < 16; i++) begin
            do_term(4'(i), 20'(i * 3), 5'(i), 16'(i + 1), t0 + 64'(i * 5));
        end
        @(negedge clk);
        term_valid = 1'b1; term_reason = 4'hE; term_size = 20'd99;
        term_rsw = 5'd7; term_iav = 16'd5; gtime = t0 + 64'd200;
        #1;
        check(stall === 1'b1, "R9 stall when full", 512'(stall), 512'(1));
        repeat (3) @(negedge clk);
        check(stall === 1'b1, "R9 stall held", 512'(stall), 512'(1));
        drain_line("R9 pre-stall");
        check(stall === 1'b0, "R9 released after line taken", 512'(stall), 512'(0));
        @(posedge clk);
        model_accept(4'hE, 20'd99, 5'd7, 16'd5, t0 + 64'd200);
        @(negedge clk);
        term_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            do_term(4'd5, 20'(i), 5'd0, 16'd0, t0 + 64'd300 + 64'(i));
        end
        for (int i = 0; i < 4; i++) begin
            drain_line("R9 R6 order");
        end
        check(mem_req === 1'b0, "R9 all lines drained", 512'(mem_req), 512'(0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_line();
        t_overflow();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule